// File: doc/BRIEF.md
# Programmable Baud-Rate Generator

This block divides a selectable input clock down to a square wave that serves as the bit clock of a serial channel. The same wave feeds both the transmit and the receive clock inputs, and it can also be driven out on a clock pin. The division is set by a 16-bit time constant TC, which is written one byte at a time. The output half-period is TC + 2 input-clock ticks, so the full period is 2 × (TC + 2) ticks.

To reach a target baud rate with clock mode M from an input frequency F, set TC = F / (2 × baud × M) − 2. For example, 2.4576 MHz, 9600 baud and ×16 mode give TC = 6. The resulting data rate must stay below a quarter of the core clock rate. The host writes the time constant and the source first with the generator stopped, and then starts it with a separate write. A command write returns every setting to the disabled reset state.

The whole block runs on the core clock `clk`. When the external pin is the source, its rising edges pass through a two-stage synchronizer and become single-cycle count enables. In that mode, the input clock must be slower than a quarter of `clk`.

Top module: `brg_top`

## Requirements
- R1: After reset, `brg_clk` and `brg_pin` are low, TC is 0, the generator is stopped, the source is the core clock and pin drive is off.
- R2: With the core clock as source, `brg_clk` first rises TC + 2 edges after the edge that samples the start write, and then toggles every TC + 2 cycles.
- R3: Address 0 holds TC bits 7:0 and address 1 holds TC bits 15:8. The control register is at address 2, with bit 0 = run, bit 1 = source (1 = external pin) and bit 2 = pin drive.
- R4: A write that clears run forces `brg_clk` low from the next edge on. While stopped, the counter holds its load value, so a restart again gives a first rise after TC + 2 cycles.
- R5: A TC write while the generator runs leaves the half-period in progress unchanged and sets the length of the half-periods that follow.
- R6: With the external source, the generator counts rising edges of `ext_clk` after a two-flop synchronizer, and toggles every TC + 2 such edges.
- R7: A change of the source bit while running has no effect until the generator has been stopped.
- R8: `brg_pin` follows `brg_clk` when pin drive is set and is low otherwise.
- R9: A write to address 3 with bit 0 set restores the full reset state of R1.
- R10: TC = 0 gives the fastest output, with a half-period of 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, used for register writes and as the core source |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | External clock pin, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| brg_clk | output | 1 | Generated clock to the transmitter and receiver |
| brg_pin | output | 1 | Generated clock, gated by pin drive |

## Verification
Each write is sampled on a rising edge:
- Control changes reach the counter on the next edge.
- A stop shows on `brg_clk` one edge after the write.
- A start shows as a first rise TC + 2 edges after the write.
- An external rising edge first sampled at edge k is counted at edge k + 2.

A behavioural model in the bench applies these delays with integer counters and a history of `ext_clk` samples. The bench compares the model with both outputs at every falling edge, when nothing is changing. Half-period lengths are also measured between falling-edge samples and checked against TC + 2 (or TC + 2 external periods).

// File: rtl/brg_pkg.sv
// Shared types for the baud-rate generator: control word layout and
// source encoding. Assumes the control register sits in the low bits
// of the write data byte.
package brg_pkg;

    typedef enum logic {
        SRC_CORE = 1'b0,
        SRC_PIN  = 1'b1
    } brg_src_e;

    // bit 0 run, bit 1 source, bit 2 pin drive
    typedef struct packed {
        logic     pin_drive;
        brg_src_e src;
        logic     run;
    } brg_ctrl_t;

    localparam int CTRL_W      = 3;
    localparam int CMD_RST_BIT = 0;

endpackage

// File: rtl/brg_regs.sv
// Register file of the generator: time-constant bytes, control word,
// command decode and the source selection that actually drives the
// counter. Assumes writes are synchronous to clk and one per cycle.
module brg_regs
    import brg_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int TC_BYTES = 2,
    parameter int ADDR_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    output logic [BYTE_W*TC_BYTES-1:0]   tc,
    output logic                         run,
    output brg_src_e                     src_eff,
    output logic                         pin_drive
);
    localparam int TC_W      = BYTE_W * TC_BYTES;
    localparam int CTRL_ADDR = TC_BYTES;
    localparam int CMD_ADDR  = TC_BYTES + 1;

    logic [TC_W-1:0] tc_q;
    brg_ctrl_t       ctrl_q;
    brg_src_e        src_q;
    logic            soft_rst;

    assign soft_rst = wr_en && (wr_addr == ADDR_W'(CMD_ADDR)) && wr_data[CMD_RST_BIT];

    // Time-constant byte registers, one byte per address.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            tc_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < TC_BYTES; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    tc_q[i*BYTE_W +: BYTE_W] <= wr_data;
                end
            end
        end
    end

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) begin
            ctrl_q <= brg_ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // Effective source: follows the control bit only while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            src_q <= SRC_CORE;
        end else if (!ctrl_q.run) begin
            src_q <= ctrl_q.src;
        end
    end

    assign tc        = tc_q;
    assign run       = ctrl_q.run;
    assign src_eff   = src_q;
    assign pin_drive = ctrl_q.pin_drive;

    assert_src_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.run && !soft_rst) |=> $stable(src_q));

    assert_cmd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!ctrl_q.run && tc_q == '0 && src_q == SRC_CORE));

endmodule

// File: rtl/brg_clk_sel.sv
// Input-clock selection: synchronizes the external pin, turns its rising
// edges into one-cycle enables and picks that or the core clock as the
// count enable. Assumes the pin toggles slower than a quarter of clk.
module brg_clk_sel
    import brg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_clk,
    input  brg_src_e src_sel,
    input  logic     run,
    output logic     tick
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            ext_tick;

    generate
        for (genvar s = 0; s < SH_W; s++) begin : g_stage
            // One synchronizer or edge-history stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q[s] <= 1'b0;
                end else begin
                    sh_q[s] <= (s == 0) ? ext_clk : sh_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign ext_tick = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign tick     = run & ((src_sel == SRC_PIN) ? ext_tick : 1'b1);

    assert_edge_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_tick |=> !ext_tick);

endmodule

// File: rtl/brg_counter.sv
// Down-counter and output toggle. Loads TC + 1 while stopped, counts one
// per tick and, on the tick after reaching zero, reloads and toggles, so
// each half-period is TC + 2 ticks. Assumes tick is low when not running.
module brg_counter #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [TC_W-1:0] tc,
    output logic            clk_out
);
    localparam int CNT_W = TC_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             tgl_q;

    assign load_val = CNT_W'(tc) + CNT_W'(1);

    // Count, reload and toggle; hold the load value while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= load_val;
            tgl_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q <= load_val;
                tgl_q <= ~tgl_q;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign clk_out = tgl_q;

    assert_stop_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tgl_q);

    assert_toggle_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && cnt_q == '0) |=> (tgl_q != $past(tgl_q)));

    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(tgl_q));

endmodule

// File: rtl/brg_top.sv
// Programmable baud-rate generator top: register file, input-clock
// selection and divider. Assumes all writes come on clk and ext_clk is
// asynchronous and slower than a quarter of clk.
module brg_top
    import brg_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int TC_BYTES    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(TC_BYTES + 2),
    localparam int TC_W       = BYTE_W * TC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              brg_clk,
    output logic              brg_pin
);
    logic [TC_W-1:0] tc;
    logic            run;
    brg_src_e        src_eff;
    logic            pin_drive;
    logic            tick;

    brg_regs #(
        .BYTE_W  (BYTE_W),
        .TC_BYTES(TC_BYTES),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tc       (tc),
        .run      (run),
        .src_eff  (src_eff),
        .pin_drive(pin_drive)
    );

    brg_clk_sel #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_clk(ext_clk),
        .src_sel(src_eff),
        .run    (run),
        .tick   (tick)
    );

    brg_counter #(
        .TC_W(TC_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .tc     (tc),
        .clk_out(brg_clk)
    );

    assign brg_pin = brg_clk & pin_drive;

endmodule

// File: tb/sim_brg_top.sv
`timescale 1ns/1ps
module sim_brg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       brg_clk;
    logic       brg_pin;

    brg_top u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .brg_clk(brg_clk), .brg_pin(brg_pin)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_req  = "R1";

    // Behavioural reference model state
    int m_tc = 0, m_half = 2, m_acc = 0;
    bit m_run = 0, m_src = 0, m_pin = 0, m_src_eff = 0, m_out = 0;
    bit s1 = 0, s2 = 0, s3 = 0;

    always @(posedge clk) begin
        bit tick;
        bit cmd;
        tick = m_run && (m_src_eff ? (s2 && !s3) : 1'b1);
        cmd  = wr_en && wr_addr == 2'd3 && wr_data[0];
        if (!rst_n) begin
            m_tc = 0; m_run = 0; m_src = 0; m_pin = 0; m_src_eff = 0;
            m_out = 0; m_acc = 0; m_half = 2; s1 = 0; s2 = 0; s3 = 0;
        end else begin
            if (!m_run) begin
                m_out = 0; m_acc = 0; m_half = m_tc + 2;
            end else if (tick) begin
                m_acc++;
                if (m_acc == m_half) begin
                    m_out = !m_out; m_acc = 0; m_half = m_tc + 2;
                end
            end
            if (!m_run) m_src_eff = m_src;
            s3 = s2; s2 = s1; s1 = ext_clk;
            if (cmd) begin
                m_tc = 0; m_run = 0; m_src = 0; m_pin = 0; m_src_eff = 0;
            end else if (wr_en) begin
                case (wr_addr)
                    2'd0: m_tc = (m_tc & 32'hFF00) | int'(wr_data);
                    2'd1: m_tc = (m_tc & 32'h00FF) | (int'(wr_data) << 8);
                    2'd2: begin m_run = wr_data[0]; m_src = wr_data[1]; m_pin = wr_data[2]; end
                    default: ;
                endcase
            end
        end
    end

    // Compare outputs with the model at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (brg_clk !== m_out || brg_pin !== (m_out & m_pin)) begin
                n_fail++;
                $display("FAIL %s model compare: clk/pin actual %b/%b expected %b/%b",
                         cur_req, brg_clk, brg_pin, m_out, m_out & m_pin);
            end
        end
    end

    // External clock source: toggles every 3 core cycles when on
    bit ext_on = 0;
    int ext_div = 0;
    always @(negedge clk) begin
        if (ext_on) begin
            ext_div++;
            if (ext_div == 3) begin
                ext_div = 0;
                ext_clk = ~ext_clk;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Cycles from the start write until the first rise
    task automatic first_rise(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!brg_clk && n < 70000);
    endtask

    // Length in cycles of the next complete half-period
    task automatic measure_half(output int n);
        logic v;
        int guard = 0;
        v = brg_clk;
        do begin @(negedge clk); guard++; end while (brg_clk == v && guard < 70000);
        v = brg_clk;
        n = 0;
        do begin @(negedge clk); n++; end while (brg_clk == v && n < 70000);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired during %s", cur_req);
            report();
        end
    end

    initial begin
        int n;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 clk after reset", brg_clk, 0);
        check("R1 pin after reset", brg_pin, 0);

        // R3 / R2: TC = 6 from the byte registers
        cur_req = "R2";
        wr(2'd0, 8'h06); wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        first_rise(n);    check("R2 first rise", n, 8);
        measure_half(n);  check("R2 half period TC=6", n, 8);

        // R8: pin drive
        cur_req = "R8";
        wr(2'd2, 8'h05);
        idle(20);
        check("R8 pin follows clk", brg_pin, brg_clk);
        wr(2'd2, 8'h01);
        idle(5);
        check("R8 pin off", brg_pin, 0);

        // R5: TC change while running
        cur_req = "R5";
        measure_half(n);
        wr(2'd0, 8'h0A);
        measure_half(n);  check("R5 new TC after reload", n, 12);

        // R4: stop forces low and restart
        cur_req = "R4";
        @(negedge clk); while (!brg_clk) @(negedge clk);
        wr(2'd2, 8'h00);
        @(negedge clk);   check("R4 low after stop", brg_clk, 0);
        idle(30);         check("R4 stays low", brg_clk, 0);
        wr(2'd2, 8'h01);
        first_rise(n);    check("R4 restart first rise", n, 12);

        // R3: high byte
        cur_req = "R3";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h02); wr(2'd1, 8'h01);
        wr(2'd2, 8'h01);
        first_rise(n);    check("R3 first rise TC=0x102", n, 260);
        measure_half(n);  check("R3 half period TC=0x102", n, 260);

        // R10: TC = 0
        cur_req = "R10";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        measure_half(n);  check("R10 half period TC=0", n, 2);

        // R6: external source, TC = 1, pin period 6 cycles
        cur_req = "R6";
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h02);
        idle(3);
        ext_on = 1'b1;
        wr(2'd2, 8'h03);
        measure_half(n);
        measure_half(n);  check("R6 half period ext", n, 18);

        // R7: source change while running is ignored
        cur_req = "R7";
        wr(2'd2, 8'h01);
        measure_half(n);
        measure_half(n);  check("R7 source held while running", n, 18);
        wr(2'd2, 8'h00);
        idle(3);
        wr(2'd2, 8'h01);
        measure_half(n);  check("R7 source applied after stop", n, 3);

        // R9: command reset
        cur_req = "R9";
        wr(2'd2, 8'h05);
        idle(7);
        wr(2'd3, 8'h01);
        @(negedge clk);   check("R9 clk low after command", brg_clk, 0);
        check("R9 pin low after command", brg_pin, 0);
        ext_on = 1'b0;
        wr(2'd2, 8'h01);
        measure_half(n);  check("R9 TC back to 0", n, 2);
        idle(10);
        done = 1'b1;
        report();
    end
endmodule